// File: doc/BRIEF.md
# Bit-Sliced Galois-Field Constant Multiplier

This block multiplies many field elements of GF(2^m) by one shared constant in a single clock. The operands arrive in bit-plane form. Plane k is a word of LANES bits, and bit l of that word is bit k of the element in lane l. Every lane passes through the same xor network, so the cost of one multiplier covers LANES products. The planes never shift across lanes.

Inside, the block builds the powers A·2^k mod P for k = 0..m-1. Each doubling only re-wires the planes: plane j moves to plane j+1, and the old top plane is xored into every plane where the reduction polynomial has a tap. The result is the xor of the powers selected by the set bits of the constant. The result is registered, and a valid strobe travels alongside it with one cycle of latency. The field width and the polynomial are parameters. The default is GF(2^8) with polynomial 0x11D, and a 3-bit field with polynomial 1011b serves as a small worked configuration.

Top module: `gfbs_mul`

## Requirements
- R1: While reset is asserted, and in the first cycle after reset is released, `outValid` is 0 and every bit of `outPlanes` is 0.
- R2: `outValid` equals the value of `inValid` sampled at the previous rising clock edge.
- R3: When `inValid` is 1 at a rising edge, each lane of `outPlanes` after that edge holds the GF(2^WIDTH) product of the matching input lane and `coeff`, reduced modulo `POLY`. The lanes are independent. Lane l's bit k sits at plane bit index k*LANES + l, on both input and output.
- R4: An accepted `coeff` of 0 gives all-zero output planes.
- R5: An accepted `coeff` of 1 copies the input planes unchanged to the output.
- R6: When `inValid` is 0 at an edge, `outPlanes` keeps its previous value, whatever `inPlanes` and `coeff` carry.
- R7: With WIDTH=3 and POLY=1011b, multiplying by 2 gives the bits (a1, a0^a2, a2) from high to low.
- R8: With WIDTH=3 and POLY=1011b, multiplying by 5 gives the bits (a0, a2, a0^a1) from high to low, so that 7·5=6 and 2·5=1.
- R9: With the defaults WIDTH=8 and POLY=0x11D, every constant from 0 to 255 gives the correct field product on every lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the block acts on the rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | The input planes and the constant are valid this cycle |
| inPlanes | input | WIDTH*LANES | Operand bit planes; plane k is bits [k*LANES +: LANES] |
| coeff | input | WIDTH | Constant multiplier, shared by all lanes |
| outValid | output | 1 | The product planes were updated at the last edge |
| outPlanes | output | WIDTH*LANES | Registered product bit planes, in the same layout as the input |

## Verification
The hardest cases to reach are the deep doublings. A lane's high bits must be reduced through the polynomial taps several times in a row, and a network with a wrong tap still gives correct results for small operands and small constants. The stimulus therefore sweeps every constant from 0 to 255. Each constant is applied to fresh random lanes, and one lane is forced to 0xFF so the top plane feeds every reduction stage. Separately, all eight 3-bit values are placed in the eight lanes at once. They are checked against the closed-form bit equations for multiplying by 2 and by 5.

// File: rtl/gfbs_pkg.sv
package gfbs_pkg;
  // Strobes from the control to the datapath
  typedef struct packed {
    logic capture;  // load the product register this cycle
  } gfbs_strobe_t;
endpackage

// File: rtl/gfbs_ctrl.sv
module gfbs_ctrl
  import gfbs_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  output gfbs_strobe_t strobe,
  output logic         outValid
);
  always_comb strobe.capture = inValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (outValid == $past(inValid))) else $error("valid latency"); // R2

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rstN |=> !outValid) else $error("outValid after reset"); // R1
endmodule

// File: rtl/gfbs_datapath.sv
module gfbs_datapath
  import gfbs_pkg::*;
#(
  parameter int unsigned       WIDTH = 8,
  parameter int unsigned       LANES = 64,
  parameter logic [WIDTH:0]    POLY  = 9'h11D
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  gfbs_strobe_t             strobe,
  input  logic [WIDTH*LANES-1:0]   inPlanes,
  input  logic [WIDTH-1:0]         coeff,
  output logic [WIDTH*LANES-1:0]   outPlanes
);
  localparam int unsigned TOP = WIDTH - 1;

  // powPlane[k][j]: plane j of A * 2^k mod POLY
  logic [LANES-1:0] powPlane [WIDTH][WIDTH];
  logic [WIDTH-1:0][LANES-1:0] prodPlane;

  for (genvar k = 0; k < WIDTH; k++) begin : g_pow
    for (genvar j = 0; j < WIDTH; j++) begin : g_plane
      if (k == 0) begin : g_base
        assign powPlane[0][j] = inPlanes[j*LANES +: LANES];
      end else if (j == 0) begin : g_low
        if (POLY[0]) begin : g_tap
          assign powPlane[k][0] = powPlane[k-1][TOP];
        end else begin : g_notap
          assign powPlane[k][0] = '0;
        end
      end else begin : g_mid
        if (POLY[j]) begin : g_tap
          assign powPlane[k][j] = powPlane[k-1][j-1] ^ powPlane[k-1][TOP];
        end else begin : g_notap
          assign powPlane[k][j] = powPlane[k-1][j-1];
        end
      end
    end
  end

  always_comb begin
    for (int j = 0; j < WIDTH; j++) begin
      prodPlane[j] = '0;
      for (int k = 0; k < WIDTH; k++) begin
        if (coeff[k]) prodPlane[j] = prodPlane[j] ^ powPlane[k][j];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                outPlanes <= '0;
    else if (strobe.capture)  outPlanes <= prodPlane;
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(strobe.capture)) |-> $stable(outPlanes)) else $error("hold"); // R6

  AST_ZERO_COEFF: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(strobe.capture) && ($past(coeff) == '0)) |-> (outPlanes == '0)) else $error("zero"); // R4

  AST_UNIT_COEFF: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(strobe.capture) && ($past(coeff) == WIDTH'(1)))
      |-> (outPlanes == $past(inPlanes))) else $error("unit"); // R5
endmodule

// File: rtl/gfbs_mul.sv
module gfbs_mul
  import gfbs_pkg::*;
#(
  parameter int unsigned    WIDTH = 8,
  parameter int unsigned    LANES = 64,
  parameter logic [WIDTH:0] POLY  = 9'h11D
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   inValid,
  input  logic [WIDTH*LANES-1:0] inPlanes,
  input  logic [WIDTH-1:0]       coeff,
  output logic                   outValid,
  output logic [WIDTH*LANES-1:0] outPlanes
);
  gfbs_strobe_t strobe;

  gfbs_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  gfbs_datapath #(.WIDTH(WIDTH), .LANES(LANES), .POLY(POLY)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .inPlanes  (inPlanes),
    .coeff     (coeff),
    .outPlanes (outPlanes)
  );
endmodule

// File: tb/gfbs_mul_bench.sv
module gfbs_mul_bench;
  typedef logic [7:0] lane8_t [8];
  typedef logic [2:0] lane3_t [8];

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic        v8 = 1'b0, ov8;
  logic [63:0] p8 = '0, op8;
  logic [7:0]  c8 = '0;
  logic        v3 = 1'b0, ov3;
  logic [23:0] p3 = '0, op3;
  logic [2:0]  c3 = '0;

  gfbs_mul #(.WIDTH(8), .LANES(8), .POLY(9'h11D)) u_gfbs_mul (
    .clk(clk), .rstN(rstN), .inValid(v8), .inPlanes(p8), .coeff(c8),
    .outValid(ov8), .outPlanes(op8));

  gfbs_mul #(.WIDTH(3), .LANES(8), .POLY(4'hB)) u_gfbs_mul_w3 (
    .clk(clk), .rstN(rstN), .inValid(v3), .inPlanes(p3), .coeff(c3),
    .outValid(ov3), .outPlanes(op3));

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  // Scalar shift-and-xor reference
  function automatic int gfMul(int a, int b, int w, int poly);
    int r = 0;
    for (int i = 0; i < w; i++) begin
      if ((b >> i) & 1) r ^= a;
      a = a << 1;
      if ((a >> w) & 1) a ^= poly;
    end
    return r;
  endfunction

  task automatic check(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Drive one cycle on the 8-bit instance and compare on the next negedge
  task automatic step8(input logic val, input lane8_t a, input logic [7:0] b,
                       input lane8_t exp, input string tag);
    v8 = val; c8 = b;
    for (int l = 0; l < 8; l++)
      for (int k = 0; k < 8; k++) p8[k*8 + l] = a[l][k];
    @(posedge clk);
    @(negedge clk);
    check({tag, " valid"}, int'(ov8), int'(val));
    for (int l = 0; l < 8; l++) begin
      logic [7:0] got;
      for (int k = 0; k < 8; k++) got[k] = op8[k*8 + l];
      check(tag, int'(got), int'(exp[l]));
    end
  endtask

  task automatic step3(input logic val, input lane3_t a, input logic [2:0] b,
                       input lane3_t exp, input string tag);
    v3 = val; c3 = b;
    for (int l = 0; l < 8; l++)
      for (int k = 0; k < 3; k++) p3[k*8 + l] = a[l][k];
    @(posedge clk);
    @(negedge clk);
    check({tag, " valid"}, int'(ov3), int'(val));
    for (int l = 0; l < 8; l++) begin
      logic [2:0] got;
      for (int k = 0; k < 3; k++) got[k] = op3[k*8 + l];
      check(tag, int'(got), int'(exp[l]));
    end
  endtask

  initial begin
    #1600000;
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    lane8_t a8, e8, last8;
    lane3_t a3, e3;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 outValid", int'(ov8), 0);
    check("R1 outPlanes", int'(op8 != '0), 0);
    check("R1 outPlanes w3", int'(op3 != '0), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", int'(ov8 | (op8 != '0)), 0);

    // R4 / R5: constants 0 and 1
    for (int l = 0; l < 8; l++) begin a8[l] = 8'($urandom); e8[l] = '0; end
    step8(1'b1, a8, 8'd0, e8, "R4 coeff0");
    step8(1'b1, a8, 8'd1, a8, "R5 coeff1");

    // R9 / R3: every constant, random lanes, one lane saturated
    for (int b = 0; b < 256; b++) begin
      for (int l = 0; l < 8; l++) a8[l] = 8'($urandom);
      a8[b % 8] = 8'hFF;
      for (int l = 0; l < 8; l++) e8[l] = 8'(gfMul(int'(a8[l]), b, 8, 'h11D));
      step8(1'b1, a8, 8'(b), e8, "R9 R3 sweep");
      last8 = e8;
    end

    // R6 / R2: idle cycles hold the output and drop valid
    for (int n = 0; n < 3; n++) begin
      for (int l = 0; l < 8; l++) a8[l] = 8'($urandom);
      step8(1'b0, a8, 8'($urandom), last8, "R6 R2 hold");
    end
    for (int l = 0; l < 8; l++) begin a8[l] = 8'(l * 37 + 3); e8[l] = 8'(gfMul(int'(a8[l]), 'h53, 8, 'h11D)); end
    step8(1'b1, a8, 8'h53, e8, "R2 R3 resume");

    // R7: 3-bit doubling, closed-form bits
    for (int l = 0; l < 8; l++) begin
      a3[l] = 3'(l);
      e3[l] = {a3[l][1], a3[l][0] ^ a3[l][2], a3[l][2]};
    end
    step3(1'b1, a3, 3'd2, e3, "R7 double");

    // R8: 3-bit multiply by 5; lane 7 -> 6, lane 2 -> 1
    for (int l = 0; l < 8; l++) e3[l] = {a3[l][0], a3[l][2], a3[l][0] ^ a3[l][1]};
    step3(1'b1, a3, 3'd5, e3, "R8 times5");
    check("R8 7*5", int'(e3[7]), 6);
    check("R8 2*5", int'(e3[2]), 1);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule